// File: doc/BRIEF.md
# PPS-Aligned Video Frame Timestamper

This block ties each video frame to satellite time. A decoded time value (whole seconds) arrives on a strobed input whenever the time decoder finishes a message. On each rising edge of the pulse-per-second input, the block takes that latest value plus one second and holds it as the current epoch. The message describes the epoch that has just ended, so the new second is one later. The same edge restarts a sub-second tick counter that runs on the system clock (20 ns per tick at 50 MHz).

When a video frame start rises, the block emits one 64-bit record. The record holds the epoch seconds, the tick count since the last pulse (the acquisition delay) and the receiver clock bias present on its input. Both asynchronous inputs, the pulse and the frame start, pass through flop synchronizers, and only their rising edges act.

A small state machine tracks the time reference. ACQUIRE is the state after reset: no pulse has been seen yet. On the first pulse edge, ACQUIRE goes to TRACK. If TRACK sees no pulse edge for one and a half seconds, it goes to HOLDOVER. Any pulse edge in HOLDOVER returns the machine to TRACK. Frames are stamped in TRACK and in HOLDOVER, and HOLDOVER raises a missing-reference flag.

Top module: `pps_frame_stamper`

## Requirements
- R1: After reset, `rec_valid` and `pps_missing` are 0, and the state is ACQUIRE.
- R2: In ACQUIRE, a frame-start rising edge produces no record unless a pulse edge falls in the same cycle.
- R3: On a pulse edge, the held epoch becomes the last time value accepted with `time_valid` high, plus one. Values presented while `time_valid` is low are ignored. The epoch sits in record bits [31:0].
- R4: The delay field, record bits [47:32], is stored little-endian: the low byte is at [39:32] and the high byte at [47:40]. It equals the number of clock cycles between the pulse edge and the frame edge, minus one. A frame edge arriving k ≥ 1 cycles after the pulse input rises, with equal synchronizer latency on both inputs, gives a delay of k−1.
- R5: The bias field, record bits [63:48], carries `clk_bias` as it was when the frame edge was detected. It is stored with its low byte at [55:48].
- R6: Each frame-start rising edge yields exactly one `rec_valid` pulse one cycle wide. A frame-start input held high yields no further records.
- R7: When a pulse edge and a frame edge fall in the same cycle, the record carries the new epoch and a delay of 0.
- R8: The delay counter stops at 0xFFFF and does not wrap while pulses are absent.
- R9: `pps_missing` rises once TICKS_PER_SEC*3/2 cycles have passed with no pulse edge (state HOLDOVER). It clears in the cycle after the next pulse edge (state TRACK).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one delay tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| pps_in | input | 1 | Asynchronous pulse-per-second |
| frame_in | input | 1 | Asynchronous video frame start (vsync) |
| time_valid | input | 1 | Strobe qualifying `time_sec` |
| time_sec | input | 32 | Decoded epoch seconds of the previous second |
| clk_bias | input | 16 | Receiver clock bias |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_data | output | 64 | {bias, delay, seconds} record |
| pps_missing | output | 1 | Pulse reference lost (HOLDOVER) |

## Verification
The two functions that can fall in the same cycle are the restart of the epoch and counter on a pulse edge, and the capture of a record on a frame edge. The bench raises both asynchronous inputs on the same falling clock edge. Because both go through synchronizers of equal depth, the two detected edges land in one cycle. The record is judged correct only if it holds the incremented second with a zero delay, and the same case is also checked from ACQUIRE, where only the coincident pulse allows a record.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
    localparam int SEC_W  = 32;
    localparam int DLY_W  = 16;
    localparam int BIAS_W = 16;
    localparam int REC_W  = SEC_W + DLY_W + BIAS_W;

    typedef enum logic [1:0] {
        ST_ACQUIRE  = 2'd0,
        ST_TRACK    = 2'd1,
        ST_HOLDOVER = 2'd2
    } pfs_state_e;

    typedef struct packed {
        logic [BIAS_W-1:0] bias;
        logic [DLY_W-1:0]  delay;
        logic [SEC_W-1:0]  sec;
    } pfs_record_t;
endpackage

// File: rtl/pfs_edge_sync.sv
module pfs_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= async_in;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) last <= 1'b0;
        else        last <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/pfs_tick_counter.sv
module pfs_tick_counter #(
    parameter int CNT_W      = 16,
    parameter int MISS_LIMIT = 75_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] dly_cnt,
    output logic             miss_hit
);
    localparam int MISS_W = $clog2(MISS_LIMIT + 1);
    localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(MISS_LIMIT - 1);

    logic [MISS_W-1:0] miss_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                dly_cnt <= '0;
        else if (restart)          dly_cnt <= '0;
        else if (dly_cnt != '1)    dly_cnt <= dly_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                   miss_cnt <= '0;
        else if (restart)             miss_cnt <= '0;
        else if (miss_cnt != MISS_LAST) miss_cnt <= miss_cnt + 1'b1;
    end

    assign miss_hit = (miss_cnt == MISS_LAST);
endmodule

// File: rtl/pps_frame_stamper.sv
module pps_frame_stamper
    import pfs_pkg::*;
#(
    parameter int TICKS_PER_SEC = 50_000_000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pps_in,
    input  logic              frame_in,
    input  logic              time_valid,
    input  logic [SEC_W-1:0]  time_sec,
    input  logic [BIAS_W-1:0] clk_bias,
    output logic              rec_valid,
    output logic [REC_W-1:0]  rec_data,
    output logic              pps_missing
);
    localparam int MISS_LIMIT = (TICKS_PER_SEC * 3) / 2;

    pfs_state_e        state, state_nx;
    logic              pps_edge, frame_edge, miss_hit, stamp;
    logic [DLY_W-1:0]  dly_cnt;
    logic [SEC_W-1:0]  last_time, epoch, epoch_nx;
    pfs_record_t       rec_nx;

    pfs_edge_sync #(.STAGES(SYNC_STAGES)) u_pps_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pps_in), .rise(pps_edge)
    );

    pfs_edge_sync #(.STAGES(SYNC_STAGES)) u_frame_sync (
        .clk(clk), .rst_n(rst_n), .async_in(frame_in), .rise(frame_edge)
    );

    pfs_tick_counter #(.CNT_W(DLY_W), .MISS_LIMIT(MISS_LIMIT)) u_ticks (
        .clk(clk), .rst_n(rst_n), .restart(pps_edge),
        .dly_cnt(dly_cnt), .miss_hit(miss_hit)
    );

    // newest accepted time, including one arriving in this cycle
    assign epoch_nx = (time_valid ? time_sec : last_time) + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_time <= '0;
            epoch     <= '0;
        end else begin
            if (time_valid) last_time <= time_sec;
            if (pps_edge)   epoch     <= epoch_nx;
        end
    end

    // state transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ACQUIRE:  if (pps_edge) state_nx = ST_TRACK;
            ST_TRACK:    if (!pps_edge && miss_hit) state_nx = ST_HOLDOVER;
            ST_HOLDOVER: if (pps_edge) state_nx = ST_TRACK;
            default:     state_nx = ST_ACQUIRE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_ACQUIRE;
        else        state <= state_nx;
    end

    // record assembly
    assign stamp = frame_edge && (state != ST_ACQUIRE || pps_edge);

    always_comb begin
        rec_nx.sec   = pps_edge ? epoch_nx : epoch;
        rec_nx.delay = pps_edge ? '0 : dly_cnt;
        rec_nx.bias  = clk_bias;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid   <= 1'b0;
            rec_data    <= '0;
            pps_missing <= 1'b0;
        end else begin
            rec_valid   <= stamp;
            pps_missing <= (state_nx == ST_HOLDOVER);
            if (stamp) rec_data <= rec_nx;
        end
    end
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker
    import pfs_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             pps_edge,
    input logic             frame_edge,
    input logic             miss_hit,
    input pfs_state_e       state,
    input logic [DLY_W-1:0] dly_cnt,
    input logic             rec_valid,
    input logic [REC_W-1:0] rec_data,
    input logic             pps_missing
);
    // R6: a record strobe never lasts two cycles and always follows a frame edge
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> !rec_valid);
    a_r6_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> $past(frame_edge));

    // R2: no record from a lone frame edge before the first pulse
    a_r2_no_stamp_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_edge && !pps_edge && state == ST_ACQUIRE) |=> !rec_valid);

    // R7: coincident edges give a zero delay
    a_r7_coincident_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_edge && pps_edge) |=> (rec_valid && rec_data[47:32] == '0));

    // R8: the counter holds at all-ones
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!pps_edge && dly_cnt == '1) |=> dly_cnt == '1);

    // R9: flag clears after a pulse, sets after the window runs out in TRACK
    a_r9_missing_clear: assert property (@(posedge clk) disable iff (!rst_n)
        pps_edge |=> !pps_missing);
    a_r9_missing_set: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRACK && miss_hit && !pps_edge) |=> pps_missing);
endmodule

bind pps_frame_stamper pfs_checker u_pfs_checker (
    .clk(clk), .rst_n(rst_n), .pps_edge(pps_edge), .frame_edge(frame_edge),
    .miss_hit(miss_hit), .state(state), .dly_cnt(dly_cnt),
    .rec_valid(rec_valid), .rec_data(rec_data), .pps_missing(pps_missing)
);

// File: tb/pps_frame_stamper_bench.sv
module pps_frame_stamper_bench;
    localparam int TPS   = 200;
    localparam int NVEC  = 6;
    // each vector: {gap k (16), bias (16), decoded time (32)}
    localparam logic [63:0] VEC [NVEC] = '{
        {16'd0,   16'h063C, 32'd1531490241},
        {16'd1,   16'h0001, 32'd1531490242},
        {16'd5,   16'hA55A, 32'd7},
        {16'd37,  16'h1234, 32'hFFFF_FFF0},
        {16'd120, 16'hFFFF, 32'd1000},
        {16'd250, 16'h0000, 32'd42}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pps_in = 1'b0, frame_in = 1'b0, time_valid = 1'b0;
    logic [31:0] time_sec = '0;
    logic [15:0] clk_bias = '0;
    logic        rec_valid, pps_missing;
    logic [63:0] rec_data;

    int checks = 0;
    int errors = 0;
    logic        got;
    logic [63:0] cap;

    always #5 clk = ~clk;

    pps_frame_stamper #(.TICKS_PER_SEC(TPS)) u_pps_frame_stamper (
        .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .frame_in(frame_in),
        .time_valid(time_valid), .time_sec(time_sec), .clk_bias(clk_bias),
        .rec_valid(rec_valid), .rec_data(rec_data), .pps_missing(pps_missing)
    );

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_time(input logic [31:0] t);
        @(negedge clk); time_sec = t; time_valid = 1'b1;
        @(negedge clk); time_valid = 1'b0;
    endtask

    // wait up to n cycles for a record, sampling at falling edges
    task automatic wait_rec(input int n);
        got = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rec_valid) begin
                got = 1'b1;
                cap = rec_data;
                break;
            end
        end
    endtask

    task automatic release_inputs();
        @(negedge clk); pps_in = 1'b0; frame_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [31:0] t;
        logic [15:0] k, b, dexp;
        int pulses;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(rec_valid == 1'b0, "R1 rec_valid", 64'(rec_valid), 0);
        check(pps_missing == 1'b0, "R1 pps_missing", 64'(pps_missing), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: frame before any pulse
        frame_in = 1'b1;
        wait_rec(10);
        check(!got, "R2 unlocked frame", 64'(got), 0);
        release_inputs();

        // R3: non-strobed time value ignored
        set_time(32'd500);
        @(negedge clk); time_sec = 32'd9999;
        pps_in = 1'b1;
        repeat (10) @(negedge clk);
        clk_bias = 16'h0BEE; frame_in = 1'b1;
        wait_rec(10);
        check(got && cap[31:0] == 32'd501, "R3 epoch from strobed time", cap, 64'd501);
        check(cap[63:48] == 16'h0BEE, "R5 bias field", cap, 64'h0BEE);
        // R6: held-high frame gives no more records
        pulses = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rec_valid) pulses++;
        end
        check(pulses == 0, "R6 held frame", 64'(pulses), 0);
        release_inputs();

        // table of vectors
        for (int v = 0; v < NVEC; v++) begin
            {k, b, t} = VEC[v];
            set_time(t);
            clk_bias = b;
            @(negedge clk);
            pps_in = 1'b1;
            if (k == 0) frame_in = 1'b1;
            else begin
                repeat (k) @(negedge clk);
                frame_in = 1'b1;
            end
            wait_rec(20);
            dexp = (k == 0) ? 16'd0 : k - 16'd1;
            check(got && cap[31:0] == t + 32'd1, "R3 epoch", cap[31:0], 64'(t + 32'd1));
            // R4 (R7 when k is 0): delay little-endian bytes
            check(cap[39:32] == dexp[7:0] && cap[47:40] == dexp[15:8],
                  (k == 0) ? "R7 coincident delay" : "R4 delay", cap[47:32], 64'(dexp));
            check(cap[63:48] == b, "R5 bias", cap[63:48], 64'(b));
            @(negedge clk);
            check(!rec_valid, "R6 single pulse", 64'(rec_valid), 0);
            release_inputs();
        end

        // R7 from ACQUIRE: coincident edges straight after reset
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        set_time(32'd77);
        @(negedge clk); pps_in = 1'b1; frame_in = 1'b1;
        wait_rec(10);
        check(got && cap[47:0] == {16'd0, 32'd78}, "R7 coincident from acquire",
              cap[47:0], {16'd0, 32'd78});
        release_inputs();

        // R9: missing flag window (pulse rose about 6 cycles ago)
        repeat (260) @(negedge clk);
        check(!pps_missing, "R9 before window", 64'(pps_missing), 0);
        repeat (60) @(negedge clk);
        check(pps_missing, "R9 after window", 64'(pps_missing), 1);
        pps_in = 1'b1;
        repeat (5) @(negedge clk);
        check(!pps_missing, "R9 cleared", 64'(pps_missing), 0);
        pps_in = 1'b0;

        // R8: saturation after a long gap, stamped in HOLDOVER
        repeat (70000) @(negedge clk);
        frame_in = 1'b1;
        wait_rec(10);
        check(got && cap[47:32] == 16'hFFFF, "R8 saturated delay", cap[47:32], 64'hFFFF);
        check(pps_missing, "R9 holdover stamps", 64'(pps_missing), 1);
        release_inputs();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule